// File: doc/BRIEF.md
# Power-Management Event and SCI Controller

This block holds the power-management event registers of a system controller and produces the level-sensitive system control interrupt (SCI) that goes with them. Software reaches the registers through a 64-byte I/O window. The position of the window and whether it answers at all are set through two configuration registers. Both are written and read back over a small configuration port.

Three hardware event inputs (global lock, power button, real-time clock) set sticky status bits. A free-running power-management timer sets a fourth status bit each time it wraps. Software clears status bits by writing ones to them. The SCI stays high while any of these four status bits has its matching enable bit set. A separate output shows whether the timer event is armed, meaning its enable is on and its status is clear.

Top module: `pm_sci_ctrl`

## Requirements
- R1: After reset, both configuration registers, status, enable, control and the timer counter are zero. The window is closed, so io_hit is 0, and sci and tmr_armed are 0.
- R2: A configuration write to byte offset 0x40 loads a 32-bit base register, and one to offset 0x80 loads an 8-bit window-control register. Both read back on cfg_rdata at the same offsets. Any other offset reads 0, and writes to it change neither register. The window covers byte addresses whose bits 15:6 equal base bits 15:6.
- R3: io_hit is 1 only when bit 0 of the window-control register is 1 and the address falls inside the window. While io_hit is 0, io_rdata is 0 and I/O writes have no effect.
- R4: The window is word-addressed by io_waddr[5:1]. Word 0 (byte 0) is status, word 1 (byte 2) is enable, word 2 (byte 4) is control, word 4 (byte 8) is timer bits 15:0, and word 5 (byte 10) is timer bits 31:16, zero-extended. Every other word reads 0. Enable and control are 16-bit read/write registers.
- R5: A one-cycle pulse on evt_gbl, evt_pwrbtn or evt_rtc sets status bit 5, 8 or 10 respectively, and the bit is visible from the next cycle. Status bits other than 0, 5, 8 and 10 always read 0.
- R6: Writing to status clears every bit written as 1 and leaves bits written as 0 unchanged. When a set and a clear of the same bit happen in the same cycle, the set wins.
- R7: sci is 1 exactly when status AND enable is non-zero in bits 0, 5, 8 or 10. Enable bits in other positions have no effect on sci.
- R8: The timer is a TMR_W-bit counter that counts up by one every cycle from reset and wraps. Writes to the timer words do not change it.
- R9: In the cycle in which the timer wraps from all ones to zero, status bit 0 becomes 1, whatever the enable setting.
- R10: tmr_armed is 1 exactly when enable bit 0 is 1 and status bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| io_waddr | input | 15 | I/O word address (byte address bits 15:1) |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, 0 outside the window |
| io_hit | output | 1 | Address falls in the open window |
| evt_gbl | input | 1 | Global-lock event pulse |
| evt_pwrbtn | input | 1 | Power-button event pulse |
| evt_rtc | input | 1 | Real-time-clock event pulse |
| sci | output | 1 | Level-sensitive system control interrupt |
| tmr_armed | output | 1 | Timer event enabled and not yet pending |

## Verification
The assertions assume that the event inputs and the I/O and configuration strobes are synchronous to clk and stable around each rising edge. They also assume that io_wdata is valid in every cycle in which io_wr is high. The stimulus meets this by changing every input on the falling edge and dropping each strobe after one cycle. The bench runs with a 10-bit timer so that wraps arrive within a few thousand cycles. Because of that, timer status can become set during unrelated tests. Those tests therefore keep enable bit 0 clear and leave status bit 0 out of their comparisons.

// File: rtl/pm_sci_ctrl.sv
module pm_sci_ctrl #(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [15:1] io_waddr,
  input  logic        io_wr,
  input  logic [15:0] io_wdata,
  output logic [15:0] io_rdata,
  output logic        io_hit,
  input  logic        evt_gbl,
  input  logic        evt_pwrbtn,
  input  logic        evt_rtc,
  output logic        sci,
  output logic        tmr_armed
);
  localparam logic [15:0] SCI_MASK = 16'h0521;

  logic [31:0]      cfg40;
  logic [7:0]       cfg80;
  logic [15:0]      sts, en, ctl;
  logic [TMR_W-1:0] cnt;
  logic [31:0]      tmr32;
  logic [4:0]       off;
  logic             carry, wr_sts, wr_en, wr_ctl;
  logic [15:0]      set_v, clr_v;

  assign io_hit = cfg80[0] && (io_waddr[15:6] == cfg40[15:6]);
  assign off    = io_waddr[5:1];
  assign wr_sts = io_wr && io_hit && off == 5'd0;
  assign wr_en  = io_wr && io_hit && off == 5'd1;
  assign wr_ctl = io_wr && io_hit && off == 5'd2;
  assign carry  = &cnt;
  assign tmr32  = 32'(cnt);

  assign set_v = {5'b0, evt_rtc, 1'b0, evt_pwrbtn, 2'b0, evt_gbl, 4'b0, carry};
  assign clr_v = wr_sts ? io_wdata : 16'h0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg40 <= '0;
      cfg80 <= '0;
      sts   <= '0;
      en    <= '0;
      ctl   <= '0;
      cnt   <= '0;
    end else begin
      if (cfg_wr && cfg_addr == 8'h40) cfg40 <= cfg_wdata;
      if (cfg_wr && cfg_addr == 8'h80) cfg80 <= cfg_wdata[7:0];
      sts <= (sts & ~clr_v) | set_v;
      if (wr_en)  en  <= io_wdata;
      if (wr_ctl) ctl <= io_wdata;
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (cfg_addr)
      8'h40:   cfg_rdata = cfg40;
      8'h80:   cfg_rdata = {24'h0, cfg80};
      default: cfg_rdata = '0;
    endcase
  end

  always_comb begin
    io_rdata = '0;
    if (io_hit) begin
      case (off)
        5'd0:    io_rdata = sts;
        5'd1:    io_rdata = en;
        5'd2:    io_rdata = ctl;
        5'd4:    io_rdata = tmr32[15:0];
        5'd5:    io_rdata = tmr32[31:16];
        default: io_rdata = '0;
      endcase
    end
  end

  assign sci       = |(sts & en & SCI_MASK);
  assign tmr_armed = en[0] & ~sts[0];
endmodule

// File: rtl/pm_sci_ctrl_chk.sv
module pm_sci_ctrl_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_rtc,
  input logic             evt_pwrbtn,
  input logic             sci,
  input logic             io_hit,
  input logic [15:0]      sts,
  input logic [15:0]      en,
  input logic [TMR_W-1:0] cnt,
  input logic             wr_sts,
  input logic [15:0]      io_wdata,
  input logic [7:0]       cfg80
);
  assert_closed_window_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg80[0] |-> !io_hit);

  assert_rtc_sets_R5: assert property (@(posedge clk) disable iff (rst)
    evt_rtc |=> sts[10]);

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_sts && io_wdata[8] && !evt_pwrbtn) |=> !sts[8]);

  assert_sci_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    sci |-> ((en & 16'h0521) != 16'h0));

  assert_timer_counts_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == $past(cnt) + TMR_W'(1));

  assert_wrap_sets_status_R9: assert property (@(posedge clk) disable iff (rst)
    (&cnt) |=> sts[0]);
endmodule

bind pm_sci_ctrl pm_sci_ctrl_chk #(.TMR_W(TMR_W)) chk_i (.*);

// File: tb/pm_sci_ctrl_test.sv
module pm_sci_ctrl_test;
  localparam int TW  = 10;
  localparam int MOD = 1 << TW;

  logic        clk = 0, rst = 1;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [15:1] io_waddr = 0;
  logic        io_wr = 0;
  logic [15:0] io_wdata = 0, io_rdata;
  logic        io_hit, sci, tmr_armed;
  logic        evt_gbl = 0, evt_pwrbtn = 0, evt_rtc = 0;
  int          n_chk = 0, n_bad = 0, bcnt = 0;
  bit          done = 0;

  pm_sci_ctrl #(.TMR_W(TW)) uut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) bcnt <= rst ? 0 : bcnt + 1;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic io_write(logic [15:0] a, logic [15:0] d);
    @(negedge clk); io_wr = 1; io_waddr = a[15:1]; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [15:0] d);
    @(negedge clk); io_waddr = a[15:1]; #1 d = io_rdata;
  endtask

  task automatic pulse(logic [2:0] m);
    @(negedge clk); {evt_rtc, evt_pwrbtn, evt_gbl} = m;
    @(negedge clk); {evt_rtc, evt_pwrbtn, evt_gbl} = 0;
    #1;
  endtask

  function automatic logic [15:0] bitmap(logic [2:0] m);
    return (m[0] ? 16'h0020 : 16'h0) | (m[1] ? 16'h0100 : 16'h0) | (m[2] ? 16'h0400 : 16'h0);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] base;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 io_hit", io_hit, 0);
    chk("R1 sci", sci, 0);
    chk("R1 armed", tmr_armed, 0);
    cfg_addr = 8'h40; #1 chk("R1 cfg40", cfg_rdata, 0);
    cfg_addr = 8'h80; #1 chk("R1 cfg80", cfg_rdata, 0);

    // R3 writes with a closed window are ignored
    cfg_write(8'h40, 32'hABCD_1234);
    io_write(16'h1202, 16'hFFFF);
    io_read(16'h1202, d);
    chk("R3 closed rdata", d, 0);
    chk("R3 closed hit", io_hit, 0);
    cfg_write(8'h80, 32'h0000_0001);
    io_read(16'h1202, d);
    chk("R3 enable untouched", d, 0);
    chk("R3 open hit", io_hit, 1);

    // R2 readback and unrelated offsets
    cfg_write(8'h44, 32'h5555_5555);
    cfg_addr = 8'h40; #1 chk("R2 cfg40", cfg_rdata, 32'hABCD_1234);
    cfg_addr = 8'h80; #1 chk("R2 cfg80", cfg_rdata, 1);
    cfg_addr = 8'h44; #1 chk("R2 other offset", cfg_rdata, 0);

    // R2/R3 base sweep
    for (int i = 0; i < 12; i++) begin
      logic [31:0] raw;
      raw  = 32'h7F00_0000 + i * 32'h1713 + i * 32'h0000_5040;
      base = raw[15:0] & 16'hFFC0;
      cfg_write(8'h40, raw);
      io_read(base, d);           chk("R2 base hit", io_hit, 1);
      io_read(base + 16'd62, d);  chk("R2 top hit", io_hit, 1);
      if (base != 16'hFFC0) begin io_read(base + 16'd64, d); chk("R2 above miss", io_hit, 0); end
      if (base != 16'h0000) begin io_read(base - 16'd2, d);  chk("R2 below miss", io_hit, 0); end
    end
    cfg_write(8'h80, 32'h0000_0000);
    io_read(16'h1200, d);
    chk("R3 reclosed hit", io_hit, 0);
    cfg_write(8'h40, 32'h0000_1200);
    cfg_write(8'h80, 32'h0000_0001);
    base = 16'h1200;

    // R4 register map sweep
    io_write(base + 16'd4, 16'hA5C3);
    io_write(base + 16'd2, 16'h0200);
    io_write(base, 16'hFFFF);
    for (int w = 0; w < 32; w++) begin
      logic [15:0] e;
      io_read(base + 16'(w * 2), d);
      case (w)
        0: begin d = d & 16'hFFFE; e = 0; end
        1: e = 16'h0200;
        2: e = 16'hA5C3;
        4: e = 16'(bcnt % MOD);
        default: e = 0;
      endcase
      chk("R4 map", d, e);
    end

    // R8 timer write ignored
    io_write(base + 16'd8, 16'h0000);
    io_read(base + 16'd8, d);
    chk("R8 timer readonly", d, 16'(bcnt % MOD));
    io_read(base + 16'd10, d);
    chk("R8 timer high", d, 0);

    // R5/R7 sweep over events and enables (timer enable kept off)
    for (int e = 0; e < 8; e++)
      for (int m = 0; m < 8; m++) begin
        io_write(base + 16'd2, bitmap(3'(e)) | 16'h0202);
        io_write(base, 16'hFFFF);
        pulse(3'(m));
        chk("R7 sci", sci, ((m & e) != 0));
        io_read(base, d);
        chk("R5 status bits", d & 16'hFFFE, bitmap(3'(m)));
      end

    // R6 write-one-to-clear and set-wins
    io_write(base, 16'hFFFF);
    pulse(3'b111);
    io_write(base, 16'h0100);
    io_read(base, d);
    chk("R6 partial clear", d & 16'hFFFE, 16'h0420);
    io_write(base, 16'h0000);
    io_read(base, d);
    chk("R6 zero write", d & 16'hFFFE, 16'h0420);
    @(negedge clk); io_wr = 1; io_waddr = base[15:1]; io_wdata = 16'h0400; evt_rtc = 1;
    @(negedge clk); io_wr = 0; evt_rtc = 0;
    io_read(base, d);
    chk("R6 set wins", d & 16'hFFFE, 16'h0420);

    // R9/R10 timer wrap with enable on
    io_write(base + 16'd2, 16'h0001);
    while (bcnt % MOD != 100) @(negedge clk);
    io_write(base, 16'hFFFF);
    #1 chk("R10 armed", tmr_armed, 1);
    while (bcnt % MOD != MOD - 1) @(negedge clk);
    #1;
    chk("R9 before wrap", sci, 0);
    @(negedge clk); #1;
    chk("R9 wrap sets sci", sci, 1);
    chk("R10 disarmed", tmr_armed, 0);
    io_read(base, d);
    chk("R9 status bit0", d[0], 1);

    // R9 wrap with enable off
    io_write(base + 16'd2, 16'h0000);
    while (bcnt % MOD != 100) @(negedge clk);
    io_write(base, 16'hFFFF);
    io_read(base, d);
    chk("R9 cleared", d[0], 0);
    while (bcnt % MOD != 0) @(negedge clk);
    io_read(base, d);
    chk("R9 set without enable", d[0], 1);
    chk("R7 no sci without enable", sci, 0);
    chk("R10 off without enable", tmr_armed, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule